// File: doc/BRIEF.md
# Interrupt Request and Acknowledge Controller

This block collects one non-maskable and four maskable interrupt lines, all asynchronous. It brings each line into the clock domain and decides, per line, whether the line is asking for service. Request 0 is always a low-active level. Requests 1 to 3 each have a programmable trigger: low level, high level, falling edge or rising edge. It ranks what is pending and presents a single maskable request and a separate non-maskable request to the processor core.

When the core starts an acknowledge cycle, the block picks the highest-ranked enabled request and latches it. Until the cycle ends, the address bus carries all upper bits high and one low bit cleared that names that request. During a vector-table fetch, the block drives a programmable extension byte on the top eight address bits, with the low sixteen bits taken from the core. It also flags when the fetch expects a 16-bit vector for request 0.

A small write-only register port sets the enables, the trigger selections, the extension byte and the response mode of request 0.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset, intReq, nmiReq, addrEn and wideVector are low. All four requests are enabled. Requests 1 to 3 are set to low-level trigger. The extension byte is 0x00. A vector fetch then drives address 0x00 followed by fetchLow.
- R2: A level-sensed input reaches intReq two clock edges after it changes. It is not visible after only one edge.
- R3: Register 1 holds the trigger selection of request n (n = 1..3) in bits [2n-1:2n-2]. The encoding is 0 = low level, 1 = high level, 2 = falling edge, 3 = rising edge. An edge request becomes pending three clock edges after the input transition.
- R4: An edge-triggered request stays pending after its input returns to idle, until an acknowledge grants it. A level-triggered request is pending only while its input is at the active level.
- R5: Request 0 is always a low-active level request.
- R6: Register 0 bit n enables request n. A pending request that is disabled neither raises intReq nor wins an acknowledge.
- R7: Among enabled pending requests, request 0 wins over 1, 1 over 2, and 2 over 3.
- R8: A falling edge on nmiN sets nmiReq three clock edges later, whatever the enables are. While nmiReq is high, intReq is held low. A one-cycle nmiClr pulse clears nmiReq.
- R9: An ackStart pulse while intReq is high latches the winner. From the next cycle until an ackDone pulse, addrEn is high and addrOut[23:4] are all ones. In addrOut[3:0], only the bit of the granted request is zero.
- R10: An ackStart pulse while intReq is low is ignored: addrEn stays low.
- R11: When vecFetch is high outside an acknowledge cycle, addrEn is high and addrOut is {extension byte, fetchLow}. The extension byte is written through register 2.
- R12: Register 3 bits [1:0] hold the response mode of request 0. wideVector is high during a vector fetch when the last grant was request 0 and that mode is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| nmiN | input | 1 | Non-maskable request line, falling edge sensed |
| irqIn | input | 4 | Maskable request lines, asynchronous |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 enables, 1 triggers, 2 extension, 3 request 0 mode |
| regWdata | input | 8 | Register write data |
| ackStart | input | 1 | One-cycle pulse starting an acknowledge cycle |
| ackDone | input | 1 | One-cycle pulse ending an acknowledge cycle |
| nmiClr | input | 1 | One-cycle pulse clearing the non-maskable request |
| vecFetch | input | 1 | High while the core fetches a service-routine address |
| fetchLow | input | 16 | Low address bits supplied by the core during a vector fetch |
| intReq | output | 1 | Maskable interrupt request to the core |
| nmiReq | output | 1 | Non-maskable interrupt request to the core |
| addrEn | output | 1 | The block is driving addrOut |
| addrOut | output | 24 | Acknowledge pattern or vector fetch address |
| wideVector | output | 1 | The current vector fetch expects a 16-bit vector |

## Verification
The hardest situation to reach is an edge-triggered request that outlives its own input. The request must be seen while the line has already returned to idle, and it must then vanish only because an acknowledge granted it. The stimulus table reaches this for each of the three configurable lines. For each line it writes the trigger, parks the input at the idle level for that trigger, makes one active transition and releases it. It then checks that the request is still pending and that the acknowledge pattern names that line. For the level triggers, the same sequence shows the opposite outcome: the request drops on release and the acknowledge is refused. Non-maskable precedence is checked with a maskable level held active, so the suppression and return of intReq are visible.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int NUM_REQ = 4;
  parameter int ADDR_W  = 24;
  parameter int EXT_W   = 8;
  parameter int DATA_W  = 8;
  localparam int LOW_W  = ADDR_W - EXT_W;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_RISE = 2'd3
  } trig_e;

  typedef struct packed {
    logic [NUM_REQ-1:0] enable;
    trig_e [NUM_REQ-1:1] trig;
  } cfg_t;

  typedef struct packed {
    logic               ackBusy;
    logic [NUM_REQ-1:0] grant;
  } strobe_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               nmiN,
  input  logic [NUM_REQ-1:0] irqIn,
  input  logic               ackStart,
  input  logic               ackDone,
  input  logic               nmiClr,
  input  cfg_t               cfg,
  output logic               intReq,
  output logic               nmiReq,
  output strobe_t            stb
);
  localparam int LINES = NUM_REQ + 1;

  logic [LINES-1:0] syncQ [SYNC_STAGES];
  logic [LINES-1:0] prevQ, cur;
  logic [NUM_REQ-1:0] edgePendQ, pend, masked, winner, clr;
  logic [NUM_REQ-1:0] grantQ;
  logic busyQ, nmiQ, take, nmiFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '1;
      prevQ <= '1;
    end else begin
      syncQ[0] <= {nmiN, irqIn};
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign cur = syncQ[SYNC_STAGES-1];

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    trig_e mode;
    logic  isEdge, levelHit, edgeHit;
    if (i == 0) begin : g_fixed
      assign mode = TRIG_LOW;
    end else begin : g_prog
      assign mode = cfg.trig[i];
    end
    assign isEdge   = (mode == TRIG_FALL) || (mode == TRIG_RISE);
    assign levelHit = (mode == TRIG_HIGH) ? cur[i] : ~cur[i];
    assign edgeHit  = (mode == TRIG_FALL) ? (prevQ[i] & ~cur[i])
                                          : (~prevQ[i] & cur[i]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) edgePendQ[i] <= 1'b0;
      else       edgePendQ[i] <= isEdge & ((edgePendQ[i] & ~clr[i]) | edgeHit);
    end
    assign pend[i] = isEdge ? edgePendQ[i] : levelHit;
  end

  assign masked = pend & cfg.enable;

  always_comb begin
    winner = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (masked[i]) winner = NUM_REQ'(1) << i;
    end
  end

  assign nmiFall = prevQ[NUM_REQ] & ~cur[NUM_REQ];
  assign intReq  = (|masked) & ~nmiQ;
  assign take    = ackStart & ~busyQ & intReq;
  assign clr     = take ? winner : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiQ   <= 1'b0;
      busyQ  <= 1'b0;
      grantQ <= '0;
    end else begin
      nmiQ <= (nmiQ & ~nmiClr) | nmiFall;
      if (take) begin
        busyQ  <= 1'b1;
        grantQ <= winner;
      end else if (ackDone) begin
        busyQ <= 1'b0;
      end
    end
  end

  assign nmiReq      = nmiQ;
  assign stb.ackBusy = busyQ;
  assign stb.grant   = grantQ;

  a_r10_idle_ack: assert property (@(posedge clk) disable iff (!rstN)
    (ackStart && !intReq && !busyQ) |=> !busyQ);
  a_r9_grant_onehot: assert property (@(posedge clk) disable iff (!rstN)
    (ackStart && intReq && !busyQ) |=> (busyQ && $onehot(grantQ)));
  a_r8_nmi_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nmiQ) |-> $past(nmiClr));
  a_r8_nmi_blocks: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> !intReq);
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [1:0]         regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic               vecFetch,
  input  logic [LOW_W-1:0]   fetchLow,
  input  strobe_t            stb,
  output cfg_t               cfg,
  output logic               addrEn,
  output logic [ADDR_W-1:0]  addrOut,
  output logic               wideVector
);
  logic [EXT_W-1:0] extQ;
  logic [1:0]       req0ModeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg.enable <= '1;
      for (int i = 1; i < NUM_REQ; i++) cfg.trig[i] <= TRIG_LOW;
      extQ      <= '0;
      req0ModeQ <= '0;
    end else if (regWe) begin
      case (regAddr)
        2'd0: cfg.enable <= regWdata[NUM_REQ-1:0];
        2'd1: for (int i = 1; i < NUM_REQ; i++)
                cfg.trig[i] <= trig_e'(regWdata[2*i-2 +: 2]);
        2'd2: extQ <= regWdata[EXT_W-1:0];
        default: req0ModeQ <= regWdata[1:0];
      endcase
    end
  end

  always_comb begin
    addrEn  = stb.ackBusy | vecFetch;
    addrOut = '0;
    if (stb.ackBusy)  addrOut = {{(ADDR_W-NUM_REQ){1'b1}}, ~stb.grant};
    else if (vecFetch) addrOut = {extQ, fetchLow};
  end

  assign wideVector = vecFetch & ~stb.ackBusy & stb.grant[0] & (req0ModeQ == 2'd3);

  a_r9_one_cold: assert property (@(posedge clk) disable iff (!rstN)
    stb.ackBusy |-> (addrEn && (&addrOut[ADDR_W-1:NUM_REQ])
                     && $countones(addrOut[NUM_REQ-1:0]) == NUM_REQ - 1));
  a_r11_ext_byte: assert property (@(posedge clk) disable iff (!rstN)
    (vecFetch && !stb.ackBusy) |-> addrOut[ADDR_W-1:LOW_W] == extQ);
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        nmiN,
  input  logic [3:0]  irqIn,
  input  logic        regWe,
  input  logic [1:0]  regAddr,
  input  logic [7:0]  regWdata,
  input  logic        ackStart,
  input  logic        ackDone,
  input  logic        nmiClr,
  input  logic        vecFetch,
  input  logic [15:0] fetchLow,
  output logic        intReq,
  output logic        nmiReq,
  output logic        addrEn,
  output logic [23:0] addrOut,
  output logic        wideVector
);
  cfg_t    cfg;
  strobe_t stb;

  irq_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk, .rstN, .nmiN, .irqIn, .ackStart, .ackDone, .nmiClr,
    .cfg, .intReq, .nmiReq, .stb
  );

  irq_datapath u_dp (
    .clk, .rstN, .regWe, .regAddr, .regWdata, .vecFetch, .fetchLow,
    .stb, .cfg, .addrEn, .addrOut, .wideVector
  );
endmodule

// File: tb/irq_ack_ctrl_test.sv
module irq_ack_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nmiN = 1'b1;
  logic [3:0] irqIn = 4'hF;
  logic regWe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic ackStart = 1'b0, ackDone = 1'b0, nmiClr = 1'b0, vecFetch = 1'b0;
  logic [15:0] fetchLow = '0;
  logic intReq, nmiReq, addrEn, wideVector;
  logic [23:0] addrOut;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] trigShadow = 8'h00;

  always #4 clk = ~clk;

  irq_ack_ctrl uut (.*);

  // {index, trigger, idle level, edge kind}
  localparam logic [5:0] VEC [12] = '{
    {2'd1, 2'd2, 1'b1, 1'b1}, {2'd1, 2'd3, 1'b0, 1'b1},
    {2'd1, 2'd0, 1'b1, 1'b0}, {2'd1, 2'd1, 1'b0, 1'b0},
    {2'd2, 2'd2, 1'b1, 1'b1}, {2'd2, 2'd3, 1'b0, 1'b1},
    {2'd2, 2'd0, 1'b1, 1'b0}, {2'd2, 2'd1, 1'b0, 1'b0},
    {2'd3, 2'd2, 1'b1, 1'b1}, {2'd3, 2'd3, 1'b0, 1'b1},
    {2'd3, 2'd0, 1'b1, 1'b0}, {2'd3, 2'd1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    step(1);
    regWe = 1'b0;
  endtask

  task automatic ack();
    ackStart = 1'b1; step(1); ackStart = 1'b0;
  endtask

  task automatic done();
    ackDone = 1'b1; step(1); ackDone = 1'b0;
  endtask

  function automatic logic [23:0] pat(input int idx);
    return {20'hFFFFF, ~(4'b0001 << idx)};
  endfunction

  initial begin
    #(8 * 20000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(2);
    rstN = 1'b1;
    step(3);
    // R1 reset state
    chk("R1 intReq", intReq, 0);
    chk("R1 nmiReq", nmiReq, 0);
    chk("R1 addrEn", addrEn, 0);
    chk("R1 wideVector", wideVector, 0);
    vecFetch = 1'b1; fetchLow = 16'h00FF; step(0);
    chk("R1 ext byte zero", addrOut, 24'h0000FF);
    vecFetch = 1'b0;

    // R3 R4 trigger table
    foreach (VEC[k]) begin
      int idx; int mode; logic idle; logic isEdge;
      idx = VEC[k][5:4]; mode = VEC[k][3:2]; idle = VEC[k][1]; isEdge = VEC[k][0];
      trigShadow[2*idx-2 +: 2] = 2'(mode);
      wr(2'd1, trigShadow);
      irqIn[idx] = idle; step(3);
      chk("R3 idle no request", intReq, 0);
      irqIn[idx] = ~idle; step(3);
      chk("R3 active request", intReq, 1);
      irqIn[idx] = idle; step(3);
      chk("R4 pending after release", intReq, isEdge);
      ack();
      if (isEdge) begin
        chk("R9 ack pattern", addrOut, pat(idx));
        chk("R4 edge cleared by grant", intReq, 0);
        done();
      end else begin
        chk("R10 ack ignored", addrEn, 0);
      end
      chk("R9 addrEn after done", addrEn, 0);
    end

    // R2 latency and R5 on request 0
    irqIn[0] = 1'b0; step(1);
    chk("R2 not after one edge", intReq, 0);
    step(1);
    chk("R2 R5 after two edges", intReq, 1);

    // R7 priority with all low-level
    trigShadow = 8'h00; wr(2'd1, trigShadow);
    irqIn = 4'b0000; step(2);
    ack();
    chk("R7 request 0 wins", addrOut, pat(0));
    done();
    wr(2'd0, 8'h0E); ack();
    chk("R6 R7 request 1 wins", addrOut, pat(1));
    done();
    wr(2'd0, 8'h0C); ack();
    chk("R7 request 2 wins", addrOut, pat(2));
    done();
    wr(2'd0, 8'h08); ack();
    chk("R7 request 3 wins", addrOut, pat(3));
    done();
    wr(2'd0, 8'h00);
    chk("R6 all disabled", intReq, 0);
    ack();
    chk("R10 ack with nothing", addrEn, 0);
    wr(2'd0, 8'h0F);
    irqIn = 4'b1110; step(2);

    // R8 non-maskable
    nmiN = 1'b0; step(2);
    chk("R8 nmi not yet", nmiReq, 0);
    step(1);
    chk("R8 nmi set", nmiReq, 1);
    chk("R8 intReq held low", intReq, 0);
    wr(2'd0, 8'h00);
    chk("R8 nmi unmaskable", nmiReq, 1);
    wr(2'd0, 8'h0F);
    nmiClr = 1'b1; step(1); nmiClr = 1'b0;
    chk("R8 nmi cleared", nmiReq, 0);
    chk("R8 intReq returns", intReq, 1);
    nmiN = 1'b1; step(3);

    // R11 R12 vector fetch
    wr(2'd2, 8'hA5); wr(2'd3, 8'h03);
    ack();
    vecFetch = 1'b1; fetchLow = 16'h1234; step(0);
    chk("R9 ack over fetch", addrOut, pat(0));
    chk("R12 no wide during ack", wideVector, 0);
    done();
    chk("R11 fetch address", addrOut, 24'hA51234);
    chk("R11 addrEn", addrEn, 1);
    chk("R12 wide vector", wideVector, 1);
    wr(2'd3, 8'h02);
    chk("R12 mode 2 narrow", wideVector, 0);
    vecFetch = 1'b0; step(0);
    chk("R11 fetch end", addrEn, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule